// File: doc/BRIEF.md
# Register write-lock controller

This block holds four sticky permission bits for a small peripheral register file: one each for a control register, a status register, a time-compensation register and the permission register itself. Each permission bit produces a write qualifier, so a target register only sees its write strobe while its bit is 1. Software can drop a permission bit to 0 but can never raise it again; only a reset can do that.

There are two resets. The power-on reset (asynchronous, active low) restores all four bits. The software reset (synchronous, active high) restores every bit except the control-register bit. A simple synchronous bus port writes the register at byte offset 0x18 and reads it back combinationally. Once the register's own permission bit is 0, the other bits are frozen until a reset.

Top module: `wr_lock_ctrl`

## Requirements
- R1: The register answers only at byte address 0x18. Reads at any other address return 0, and writes at any other address change nothing.
- R2: A read at 0x18 returns 0 in bits 31..8 and 1 in bits 7 and 2..0, whatever was written there.
- R3: Bit positions: bit 6 is the register's own permission, bit 5 status, bit 4 control, bit 3 time-compensation.
- R4: After power-on reset the read value is 0x000000FF and all three write qualifiers pass their strobes.
- R5: An accepted write updates the bits at the next clock edge: each new bit is the old bit AND the matching write-data bit.
- R6: A write can never change a permission bit from 0 to 1.
- R7: Each write qualifier is combinational and equals the target's strobe AND its permission bit.
- R8: A software reset sets bits 6, 5 and 3 to 1 at the next edge and leaves bit 4 unchanged.
- R9: Power-on reset sets all four permission bits to 1, including bit 4.
- R10: While bit 6 is 0, writes to 0x18 are ignored.
- R11: Bit 6 is sampled before the update, so one write can clear bit 6 and other bits together.
- R12: When a software reset and a write occur in the same cycle, the software reset takes effect and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe for the bus port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| ctl_wr_req | input | 1 | Write strobe headed for the control register |
| sts_wr_req | input | 1 | Write strobe headed for the status register |
| tcp_wr_req | input | 1 | Write strobe headed for the time-compensation register |
| ctl_wr_ok | output | 1 | Qualified control-register write |
| sts_wr_ok | output | 1 | Qualified status-register write |
| tcp_wr_ok | output | 1 | Qualified time-compensation write |

## Verification
The hardest state to reach is one where the two resets have split the register: the control bit is 0 while the others are back at 1 after a software reset. Reaching it also shows that a power-on reset is still needed for bit 4. The stimulus clears bits, applies a software reset, clears bit 6 together with another bit in one write, and tries to write while frozen. It also applies a software reset in the same cycle as a write, and only then applies a power-on reset. A behavioural model compares rdata and the three qualifiers on every cycle, with strobe patterns that vary.

// File: rtl/wlk_pkg.sv
package wlk_pkg;
  localparam int N_LOCK    = 4;
  localparam int LOCK_LSB  = 3;
  localparam int IDX_TCP   = 0;
  localparam int IDX_CTL   = 1;
  localparam int IDX_STS   = 2;
  localparam int IDX_SELF  = 3;
  // bits that keep their value through a software reset
  localparam logic [N_LOCK-1:0] SW_KEEP = 4'b0010;
  localparam logic [31:0] RB_FIXED = 32'h0000_0087;

  typedef logic [N_LOCK-1:0] lock_vec_t;

  function automatic lock_vec_t next_lock(lock_vec_t cur, lock_vec_t field);
    return cur & field;
  endfunction

  function automatic logic [31:0] pack_readback(lock_vec_t lk);
    logic [31:0] r;
    r = RB_FIXED;
    r[LOCK_LSB +: N_LOCK] = lk;
    return r;
  endfunction
endpackage

// File: rtl/wlk_decode.sv
module wlk_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              sel,
  output logic              wr_hit
);
  assign sel    = (addr == OFFSET);
  assign wr_hit = sel & wr_en;
endmodule

// File: rtl/wlk_lock_bits.sv
module wlk_lock_bits
  import wlk_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      sw_rst,
  input  logic      upd,
  input  lock_vec_t field,
  output lock_vec_t lock_q
);
  lock_vec_t nxt;
  assign nxt = next_lock(lock_q, field);

  for (genvar i = 0; i < N_LOCK; i++) begin : g_bit
    if (SW_KEEP[i]) begin : g_keep
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      lock_q[i] <= 1'b1;
        else if (sw_rst) lock_q[i] <= lock_q[i];
        else if (upd)    lock_q[i] <= nxt[i];
      end
    end else begin : g_clr
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      lock_q[i] <= 1'b1;
        else if (sw_rst) lock_q[i] <= 1'b1;
        else if (upd)    lock_q[i] <= nxt[i];
      end
    end
  end
endmodule

// File: rtl/wlk_gate.sv
module wlk_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] allow,
  output logic [N-1:0] ok
);
  for (genvar i = 0; i < N; i++) begin : g_and
    assign ok[i] = req[i] & allow[i];
  end
endmodule

// File: rtl/wr_lock_ctrl.sv
module wr_lock_ctrl
  import wlk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h18
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sw_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              ctl_wr_req,
  input  logic              sts_wr_req,
  input  logic              tcp_wr_req,
  output logic              ctl_wr_ok,
  output logic              sts_wr_ok,
  output logic              tcp_wr_ok
);
  localparam int N_TGT = N_LOCK - 1;

  logic      sel;
  logic      wr_hit;
  logic      wr_accept;
  lock_vec_t lock_q;
  lock_vec_t wfield;
  logic [N_TGT-1:0] tgt_req, tgt_ok;
  logic      unused_wdata;

  assign wfield       = wdata[LOCK_LSB +: N_LOCK];
  assign unused_wdata = ^{wdata[31:LOCK_LSB+N_LOCK], wdata[LOCK_LSB-1:0]};

  wlk_decode #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_dec (
    .addr(addr), .wr_en(wr_en), .sel(sel), .wr_hit(wr_hit)
  );

  // own permission bit is sampled before the update (old value)
  assign wr_accept = wr_hit & lock_q[IDX_SELF];

  wlk_lock_bits u_bits (
    .clk(clk), .por_n(por_n), .sw_rst(sw_rst),
    .upd(wr_accept), .field(wfield), .lock_q(lock_q)
  );

  assign tgt_req[IDX_TCP] = tcp_wr_req;
  assign tgt_req[IDX_CTL] = ctl_wr_req;
  assign tgt_req[IDX_STS] = sts_wr_req;

  wlk_gate #(.N(N_TGT)) u_gate (
    .req(tgt_req), .allow(lock_q[N_TGT-1:0]), .ok(tgt_ok)
  );

  assign tcp_wr_ok = tgt_ok[IDX_TCP];
  assign ctl_wr_ok = tgt_ok[IDX_CTL];
  assign sts_wr_ok = tgt_ok[IDX_STS];

  assign rdata = sel ? pack_readback(lock_q) : 32'h0;
endmodule

// File: rtl/wlk_checker.sv
module wlk_checker
  import wlk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h18
) (
  input logic              clk,
  input logic              por_n,
  input logic              sw_rst,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              wr_hit,
  input logic              ctl_wr_req,
  input logic              ctl_wr_ok,
  input lock_vec_t         lock_q
);
  assert_no_rise_R6: assert property (@(posedge clk) disable iff (!por_n)
    !sw_rst |=> ((lock_q & ~$past(lock_q)) == '0));

  assert_sw_keep_ctl_R8: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> $stable(lock_q[IDX_CTL]));

  assert_sw_restore_R8: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> (lock_q[IDX_SELF] && lock_q[IDX_STS] && lock_q[IDX_TCP]));

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!por_n)
    (!sw_rst && !lock_q[IDX_SELF]) |=> $stable(lock_q));

  assert_and_update_R5: assert property (@(posedge clk) disable iff (!por_n)
    (wr_hit && lock_q[IDX_SELF] && !sw_rst) |=>
      (lock_q == ($past(lock_q) & $past(wdata[LOCK_LSB +: N_LOCK]))));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!por_n)
    ctl_wr_ok |-> (ctl_wr_req && lock_q[IDX_CTL]));

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!por_n)
    (addr == OFFSET) |-> (rdata[31:8] == 24'h0 && rdata[7] && rdata[2:0] == 3'b111));

  assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!por_n)
    (addr != OFFSET) |-> (rdata == 32'h0));
endmodule

bind wr_lock_ctrl wlk_checker #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_chk (
  .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .addr(addr), .wdata(wdata),
  .rdata(rdata), .wr_hit(wr_hit), .ctl_wr_req(ctl_wr_req),
  .ctl_wr_ok(ctl_wr_ok), .lock_q(lock_q)
);

// File: tb/wr_lock_ctrl_test.sv
module wr_lock_ctrl_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sw_rst = 1'b0;
  logic [7:0] addr = 8'h0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic ctl_wr_req = 1'b0, sts_wr_req = 1'b0, tcp_wr_req = 1'b0;
  logic ctl_wr_ok, sts_wr_ok, tcp_wr_ok;

  int checks = 0;
  int failures = 0;
  int cyc_n = 0;
  // model permissions: separate bits, not a vector copy
  bit m_self = 1, m_sts = 1, m_ctl = 1, m_tcp = 1;

  always #(PERIOD/2) clk = ~clk;

  wr_lock_ctrl uut (
    .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .ctl_wr_req(ctl_wr_req),
    .sts_wr_req(sts_wr_req), .tcp_wr_req(tcp_wr_req), .ctl_wr_ok(ctl_wr_ok),
    .sts_wr_ok(sts_wr_ok), .tcp_wr_ok(tcp_wr_ok)
  );

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    int v;
    if (a != 8'd24) return 32'h0;
    v = 128 + 7 + m_self * 64 + m_sts * 32 + m_ctl * 16 + m_tcp * 8;
    return 32'(v);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc_n, act, exp);
    end
  endtask

  // one bus cycle: drive, compare everything, clock, advance model
  task automatic cyc(string tag, logic [7:0] a, logic we, logic [31:0] d,
                     logic sr, logic [2:0] req);
    @(negedge clk);
    addr = a; wr_en = we; wdata = d; sw_rst = sr;
    {ctl_wr_req, sts_wr_req, tcp_wr_req} = req;
    #1;
    check({tag, " rdata"}, rdata, exp_rd(a));
    check({tag, " R7 qualifiers"}, {29'h0, ctl_wr_ok, sts_wr_ok, tcp_wr_ok},
          {29'h0, req[2] & m_ctl, req[1] & m_sts, req[0] & m_tcp});
    @(posedge clk);
    cyc_n++;
    if (sr) begin
      m_self = 1; m_sts = 1; m_tcp = 1;
    end else if (we && a == 8'd24 && m_self) begin
      if (!d[6]) m_self = 0;
      if (!d[5]) m_sts = 0;
      if (!d[4]) m_ctl = 0;
      if (!d[3]) m_tcp = 0;
    end
  endtask

  task automatic power_on;
    @(negedge clk);
    por_n = 1'b0;
    m_self = 1; m_sts = 1; m_ctl = 1; m_tcp = 1;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    power_on();
    // R4: reset state, all strobes pass
    cyc("R4", 8'h18, 0, 0, 0, 3'b111);
    check("R4 read 0xFF", rdata, 32'h0000_00FF);
    // R1: other addresses
    cyc("R1 miss read", 8'h14, 0, 0, 0, 3'b101);
    cyc("R1 miss write", 8'h14, 1, 32'h0, 0, 3'b010);
    cyc("R1 miss write", 8'h1C, 1, 32'h0, 0, 3'b000);
    cyc("R1 after miss", 8'h18, 0, 0, 0, 3'b111);
    check("R1 unchanged", rdata, 32'h0000_00FF);
    // R2: junk in fixed bits
    cyc("R2 write", 8'h18, 1, 32'hFFFF_FF78, 0, 3'b000);
    cyc("R2 read", 8'h18, 0, 0, 0, 3'b000);
    check("R2 fixed bits", rdata, 32'h0000_00FF);
    // R3/R5: clear time-compensation only
    cyc("R3 clr tcp", 8'h18, 1, 32'hFFFF_FFF7, 0, 3'b111);
    cyc("R5 read", 8'h18, 0, 0, 0, 3'b111);
    check("R3 tcp bit3", rdata, 32'h0000_00F7);
    check("R7 tcp blocked", {31'h0, tcp_wr_ok}, 32'h0);
    // R6: cannot set back
    cyc("R6 set attempt", 8'h18, 1, 32'hFFFF_FFFF, 0, 3'b000);
    cyc("R6 read", 8'h18, 0, 0, 0, 3'b011);
    check("R6 still cleared", rdata, 32'h0000_00F7);
    // R5: clear status and control
    cyc("R5 clr sts ctl", 8'h18, 1, 32'hFFFF_FFCF, 0, 3'b110);
    cyc("R5 read", 8'h18, 0, 0, 0, 3'b111);
    check("R5 and result", rdata, 32'h0000_00C7);
    // R8: software reset keeps control bit cleared
    cyc("R8 swrst", 8'h18, 0, 0, 1, 3'b000);
    cyc("R8 read", 8'h18, 0, 0, 0, 3'b111);
    check("R8 after swrst", rdata, 32'h0000_00EF);
    check("R8 ctl still blocked", {31'h0, ctl_wr_ok}, 32'h0);
    // R12: software reset beats concurrent write
    cyc("R12 swrst+write", 8'h18, 1, 32'h0, 1, 3'b000);
    cyc("R12 read", 8'h18, 0, 0, 0, 3'b000);
    check("R12 write discarded", rdata, 32'h0000_00EF);
    // R11: clear own bit and tcp in one write
    cyc("R11 clr self+tcp", 8'h18, 1, 32'hFFFF_FFB7, 0, 3'b000);
    cyc("R11 read", 8'h18, 0, 0, 0, 3'b010);
    check("R11 both cleared", rdata, 32'h0000_00A7);
    // R10: frozen
    cyc("R10 frozen write", 8'h18, 1, 32'h0, 0, 3'b111);
    cyc("R10 read", 8'h18, 0, 0, 0, 3'b111);
    check("R10 status unchanged", rdata, 32'h0000_00A7);
    check("R10 status passes", {31'h0, sts_wr_ok}, 32'h1);
    // R8 again, then R9 power-on restores control
    cyc("R8 swrst2", 8'h18, 0, 0, 1, 3'b000);
    cyc("R8 read2", 8'h18, 0, 0, 0, 3'b100);
    check("R8 ctl kept", rdata, 32'h0000_00EF);
    power_on();
    cyc("R9 read", 8'h18, 0, 0, 0, 3'b111);
    check("R9 all restored", rdata, 32'h0000_00FF);
    check("R9 ctl passes", {31'h0, ctl_wr_ok}, 32'h1);
    cyc("R9 idle", 8'h00, 0, 0, 0, 3'b000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule